// File: doc/BRIEF.md
# Calendar Clock with Leap-Year Correction

This block is a timekeeping counter for a chip that stays powered from a backup supply. A slow crystal clock drives a prescaler that produces one tick per second. Each tick advances a calendar of seconds, minutes, hours, day of month, month and a 5-bit year offset. The offset counts from a base year that is a leap year, which gives a 32-year span. February is given 29 days when the offset is a multiple of four. A configuration input picks the divide ratio, so the block runs from either of the two usual watch-crystal frequencies.

The block is cleared only by its own battery/power-on reset. The chip-wide system reset enters at a port and leaves every counter untouched. A host reads time from a holding register. One strobe copies the whole calendar into that register on a single edge, so a read never mixes fields from before and after a rollover. A load strobe writes all fields at once and restarts the prescaler, so a full second elapses before the first advance after a write.

Top module: `cal_clock`

## Requirements
- R1: While `bat_rst` is high at a clock edge, the calendar becomes 00:00:00, day 1, month 1, year offset 0; the prescaler becomes 0; and the holding register takes the same values.
- R2: `sys_rst` has no effect on the calendar, the prescaler or the holding register.
- R3: The prescaler counts 0 up to its terminal count TC and then wraps. TC is `LO_TC` (default 32767) when `freq_sel`=0 and `HI_TC` (default 65535) when `freq_sel`=1. `sec_tick` is high for exactly one cycle in every TC+1 cycles, and the calendar advances by one second on the edge that ends that cycle.
- R4: Seconds roll over from 59 to 0 with a carry into minutes. Minutes roll over from 59 to 0 with a carry into hours. Hours roll over from 23 to 0 with a carry into the day.
- R5: The day rolls over to 1 with a carry into the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in February of a non-leap year.
- R6: When the year offset modulo 4 is 0, February ends after day 29.
- R7: Month 12 rolls over to month 1 and increments the year offset. The year offset wraps from 31 to 0.
- R8: When `ld_stb` is high at an edge, all six fields take the `ld_*` values and the prescaler restarts at 0. The load takes priority over a tick on the same edge, and the first advance comes TC+1 cycles after the load edge.
- R9: When `snap_req` is high at an edge, the holding register takes the calendar value from before that edge. The `rd_*` outputs change only on such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| bat_rst | input | 1 | Dedicated battery/power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset; has no effect on this block |
| freq_sel | input | 1 | 0: low-frequency crystal ratio, 1: double-frequency ratio |
| ld_stb | input | 1 | Load strobe for all time fields |
| ld_sec | input | 6 | Seconds to load (0-59) |
| ld_min | input | 6 | Minutes to load (0-59) |
| ld_hour | input | 5 | Hours to load (0-23) |
| ld_day | input | 5 | Day of month to load (1-31) |
| ld_mon | input | 4 | Month to load (1-12) |
| ld_year | input | 5 | Year offset to load (0-31) |
| snap_req | input | 1 | Copies the calendar into the holding register |
| sec_tick | output | 1 | One-cycle pulse per second |
| rd_sec | output | 6 | Held seconds |
| rd_min | output | 6 | Held minutes |
| rd_hour | output | 5 | Held hours |
| rd_day | output | 5 | Held day of month |
| rd_mon | output | 4 | Held month |
| rd_year | output | 5 | Held year offset |

## Verification
The load edge sets the prescaler to zero. The first advance of the calendar therefore lands on the edge TC+1 cycles after the load, and each later advance comes another TC+1 cycles on. A snapshot taken W cycles after the load edge latches on the edge after that and shows the result of floor(W/(TC+1)) advances. The `rd_*` ports can be read one half-cycle after that snapshot edge. The bench runs with small terminal counts. It drives inputs and samples outputs on falling edges. It computes the expected calendar arithmetically from the advance count, and it places W both on a period boundary and one cycle before it, so that an advance one edge early or late is caught. The bench counts `sec_tick` pulses across whole periods.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 5;

    typedef struct packed {
        logic [YEAR_W-1:0] yr;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hr;
        logic [MIN_W-1:0]  mn;
        logic [SEC_W-1:0]  sc;
    } cal_t;

    localparam cal_t CAL_INIT = '{yr: '0, mon: MON_W'(1), day: DAY_W'(1),
                                  hr: '0, mn: '0, sc: '0};

    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        return (y[1:0] == 2'b00);
    endfunction

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic [YEAR_W-1:0] y);
        logic [DAY_W-1:0] n;
        unique case (m)
            MON_W'(2):                                   n = leap_year(y) ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): n = DAY_W'(30);
            default:                                     n = DAY_W'(31);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int LO_TC = 32767,
    parameter int HI_TC = 65535
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = $clog2(HI_TC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tc;

    assign tc   = sel ? CNT_W'(HI_TC) : CNT_W'(LO_TC);
    assign tick = (cnt_q >= tc);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));
    assert_count_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_clock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ld,
    input  cal_t ld_val,
    output cal_t cur
);
    cal_t cur_q;
    cal_t nxt;
    logic [DAY_W-1:0] last_day;
    logic sc_wrap, mn_wrap, hr_wrap, day_wrap, mon_wrap;

    assign last_day = month_len(cur_q.mon, cur_q.yr);
    assign sc_wrap  = (cur_q.sc == SEC_W'(59));
    assign mn_wrap  = sc_wrap  && (cur_q.mn == MIN_W'(59));
    assign hr_wrap  = mn_wrap  && (cur_q.hr == HOUR_W'(23));
    assign day_wrap = hr_wrap  && (cur_q.day >= last_day);
    assign mon_wrap = day_wrap && (cur_q.mon >= MON_W'(12));

    always_comb begin
        nxt     = cur_q;
        nxt.sc  = sc_wrap  ? '0 : cur_q.sc + 1'b1;
        if (sc_wrap)  nxt.mn  = mn_wrap  ? '0 : cur_q.mn + 1'b1;
        if (mn_wrap)  nxt.hr  = hr_wrap  ? '0 : cur_q.hr + 1'b1;
        if (hr_wrap)  nxt.day = day_wrap ? DAY_W'(1) : cur_q.day + 1'b1;
        if (day_wrap) nxt.mon = mon_wrap ? MON_W'(1) : cur_q.mon + 1'b1;
        if (mon_wrap) nxt.yr  = cur_q.yr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       cur_q <= CAL_INIT;
        else if (ld)   cur_q <= ld_val;
        else if (tick) cur_q <= nxt;
    end

    assign cur = cur_q;

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(cur_q));
    assert_sec_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && cur_q.sc < SEC_W'(59)) |=> (cur_q.sc == $past(cur_q.sc) + 1'b1));
    assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && hr_wrap) |=> (cur_q.hr == '0 && cur_q.mn == '0 && cur_q.sc == '0));
    assert_feb_leap_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && hr_wrap && cur_q.mon == MON_W'(2) && cur_q.day == DAY_W'(28)
         && leap_year(cur_q.yr)) |=> (cur_q.day == DAY_W'(29)));
    assert_year_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && mon_wrap && cur_q.yr == '1) |=> (cur_q.yr == '0 && cur_q.mon == MON_W'(1)));
    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cur_q == $past(ld_val)));

endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
    import cal_clock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grab,
    input  cal_t live,
    output cal_t held
);
    cal_t held_q;

    always_ff @(posedge clk) begin
        if (rst)       held_q <= CAL_INIT;
        else if (grab) held_q <= live;
    end

    assign held = held_q;

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !grab |=> $stable(held_q));
    assert_grab_R9: assert property (@(posedge clk) disable iff (rst)
        grab |=> (held_q == $past(live)));

endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_clock_pkg::*;
#(
    parameter int LO_TC = 32767,
    parameter int HI_TC = 65535
) (
    input  logic              clk,
    input  logic              bat_rst,
    input  logic              sys_rst,
    input  logic              freq_sel,
    input  logic              ld_stb,
    input  logic [SEC_W-1:0]  ld_sec,
    input  logic [MIN_W-1:0]  ld_min,
    input  logic [HOUR_W-1:0] ld_hour,
    input  logic [DAY_W-1:0]  ld_day,
    input  logic [MON_W-1:0]  ld_mon,
    input  logic [YEAR_W-1:0] ld_year,
    input  logic              snap_req,
    output logic              sec_tick,
    output logic [SEC_W-1:0]  rd_sec,
    output logic [MIN_W-1:0]  rd_min,
    output logic [HOUR_W-1:0] rd_hour,
    output logic [DAY_W-1:0]  rd_day,
    output logic [MON_W-1:0]  rd_mon,
    output logic [YEAR_W-1:0] rd_year
);
    cal_t ld_val, live, held;
    logic tick;

    assign ld_val = '{yr: ld_year, mon: ld_mon, day: ld_day,
                      hr: ld_hour, mn: ld_min, sc: ld_sec};

    cal_prescaler #(.LO_TC(LO_TC), .HI_TC(HI_TC)) pre_i (
        .clk(clk), .rst(bat_rst), .sel(freq_sel), .clr(ld_stb), .tick(tick)
    );

    cal_counter cnt_i (
        .clk(clk), .rst(bat_rst), .tick(tick), .ld(ld_stb),
        .ld_val(ld_val), .cur(live)
    );

    cal_snapshot snap_i (
        .clk(clk), .rst(bat_rst), .grab(snap_req), .live(live), .held(held)
    );

    assign sec_tick = tick;
    assign rd_sec   = held.sc;
    assign rd_min   = held.mn;
    assign rd_hour  = held.hr;
    assign rd_day   = held.day;
    assign rd_mon   = held.mon;
    assign rd_year  = held.yr;

    assert_sysrst_R2: assert property (@(posedge clk) disable iff (bat_rst)
        (sys_rst && !ld_stb && !tick) |=> $stable(live));
    assert_bat_rst_R1: assert property (@(posedge clk)
        bat_rst |=> (live == CAL_INIT && held == CAL_INIT));

endmodule

// File: tb/cal_clock_tb_top.sv
module cal_clock_tb_top;

    localparam int LO = 3;
    localparam int HI = 7;

    logic clk = 1'b0;
    logic bat_rst = 1'b1, sys_rst = 1'b1, freq_sel = 1'b0;
    logic ld_stb = 1'b0, snap_req = 1'b0;
    logic [5:0] ld_sec = '0, ld_min = '0;
    logic [4:0] ld_hour = '0, ld_day = 5'd1, ld_year = '0;
    logic [3:0] ld_mon = 4'd1;
    logic sec_tick;
    logic [5:0] rd_sec, rd_min;
    logic [4:0] rd_hour, rd_day, rd_year;
    logic [3:0] rd_mon;

    int total = 0, bad = 0;
    bit finished = 0;
    int ey, emo, ed, eh, emi, es;

    always #2 clk = ~clk;

    cal_clock #(.LO_TC(LO), .HI_TC(HI)) dut_i (
        .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .freq_sel(freq_sel),
        .ld_stb(ld_stb), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year), .snap_req(snap_req),
        .sec_tick(sec_tick), .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour),
        .rd_day(rd_day), .rd_mon(rd_mon), .rd_year(rd_year)
    );

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic step_one();
        es = es + 1;
        if (es == 60) begin es = 0; emi = emi + 1; end
        if (emi == 60) begin emi = 0; eh = eh + 1; end
        if (eh == 24) begin eh = 0; ed = ed + 1; end
        if (ed > mdays(emo, ey)) begin ed = 1; emo = emo + 1; end
        if (emo == 13) begin emo = 1; ey = (ey + 1) % 32; end
    endtask

    function automatic int pack(int y, int mo, int d, int h, int mi, int s);
        return (y << 26) | (mo << 22) | (d << 17) | (h << 12) | (mi << 6) | s;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int rd_packed();
        return pack(int'(rd_year), int'(rd_mon), int'(rd_day), int'(rd_hour),
                    int'(rd_min), int'(rd_sec));
    endfunction

    // load at edge P0, wait W edges, snapshot at P0+W+1, compare
    task automatic run_case(string req, bit fs, int y, int mo, int d, int h,
                            int mi, int s, int w, bit hold_sys);
        int per;
        per = (fs ? HI : LO) + 1;
        @(negedge clk);
        freq_sel = fs;
        ld_stb = 1'b1;
        ld_year = 5'(y); ld_mon = 4'(mo); ld_day = 5'(d);
        ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s);
        @(posedge clk);
        @(negedge clk);
        ld_stb = 1'b0;
        sys_rst = hold_sys;
        repeat (w) @(posedge clk);
        @(negedge clk);
        snap_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        snap_req = 1'b0;
        sys_rst = 1'b0;
        ey = y; emo = mo; ed = d; eh = h; emi = mi; es = s;
        for (int k = 0; k < w / per; k++) step_one();
        chk(req, rd_packed(), pack(ey, emo, ed, eh, emi, es));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int snapv, ticks;
        repeat (4) @(negedge clk);
        bat_rst = 1'b0;
        // R1: holding register and calendar at reset
        chk("R1 hold", rd_packed(), pack(0, 1, 1, 0, 0, 0));
        repeat (LO) @(posedge clk);
        @(negedge clk); snap_req = 1'b1; @(posedge clk); @(negedge clk); snap_req = 1'b0;
        chk("R1 cal", rd_packed(), pack(0, 1, 1, 0, 0, 0));
        sys_rst = 1'b0;

        // R4: seconds sweep across minute, hour and day carries
        for (int s = 0; s < 60; s++) run_case("R4 sec", 0, 5, 6, 15, 23, 59, s, LO + 1, 0);
        for (int m = 0; m < 60; m++) run_case("R4 min", 0, 5, 6, 15, 10, m, 59, LO + 1, 0);
        for (int h = 0; h < 24; h++) run_case("R4 hour", 0, 5, 6, 15, h, 59, 59, LO + 1, 0);

        // R5 R6 R7: every month end of every year offset
        for (int y = 0; y < 32; y++)
            for (int mo = 1; mo <= 12; mo++) begin
                run_case(mo == 2 ? "R6 feb" : (mo == 12 ? "R7 dec" : "R5 month"),
                         0, y, mo, mdays(mo, y), 23, 59, 59, LO + 1, 0);
                run_case("R5 before end", 0, y, mo, mdays(mo, y) - 1, 23, 59, 59, LO + 1, 0);
            end

        // R3 R8: period boundaries for both ratios
        for (int n = 1; n <= 6; n++) begin
            run_case("R3 lo edge", 0, 31, 12, 31, 23, 59, 55, n * (LO + 1), 0);
            run_case("R8 lo early", 0, 31, 12, 31, 23, 59, 55, n * (LO + 1) - 1, 0);
            run_case("R3 hi edge", 1, 3, 2, 28, 23, 59, 57, n * (HI + 1), 0);
            run_case("R8 hi early", 1, 3, 2, 28, 23, 59, 57, n * (HI + 1) - 1, 0);
        end

        // R3: sec_tick pulse count over five periods
        for (int f = 0; f < 2; f++) begin
            int per;
            per = (f != 0 ? HI : LO) + 1;
            @(negedge clk); freq_sel = f[0]; ld_stb = 1'b1;
            @(posedge clk); @(negedge clk); ld_stb = 1'b0;
            ticks = 0;
            for (int j = 0; j < 5 * per; j++) begin
                if (sec_tick) ticks++;
                @(negedge clk);
            end
            chk("R3 ticks", ticks, 5);
        end

        // R2: system reset held during counting
        run_case("R2 sysrst", 0, 12, 4, 30, 23, 59, 50, 20 * (LO + 1) + 2, 1);

        // R9: outputs frozen without snap_req while calendar advances
        snapv = rd_packed();
        sys_rst = 1'b1;
        repeat (10 * (LO + 1)) @(negedge clk);
        chk("R9 frozen", rd_packed(), snapv);
        sys_rst = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule